// File: doc/BRIEF.md
# Prioritised Interrupt Dispatch Controller

This controller decides at every instruction boundary whether the processor core should take an interrupt. It holds two 5-bit registers: a per-source enable mask and a per-source pending flag set. It also runs a four-state master-enable machine. Peripherals raise requests that latch into the flag register. The core reads and writes both registers through a simple write port and two read outputs. The core marks each instruction boundary with a one-cycle step strobe.

When the master enable is on and a step arrives while at least one source is both enabled and pending, the controller takes an interrupt. It picks the lowest-numbered source among those eligible, clears only that flag and drops the master enable to off. One cycle later it presents a dispatch pulse together with the vector address and the machine-cycle cost of the dispatch. The core's datapath then pushes the program counter and jumps to the vector. The stack push is not part of this block.

The master-enable states are OFF (0), SCHEDULED (1), DELAYED (2) and ON (3). The transitions are as follows. The arm transition (OFF to SCHEDULED) happens on an enable request. The first step transition goes from SCHEDULED to DELAYED. The second step transition goes from DELAYED to ON. The take transition goes from ON to OFF, on a step with a serviceable source. The kill transition goes from any state to OFF, on a disable request, and it wins over everything else in the same cycle.

Top module: `irq_dispatch_ctrl`

## Requirements
- R1: After reset, `ie_o` and `if_o` are 0, `ime_o` is 0 (OFF), `disp_valid_o` is 0, and `disp_vector_o` and `disp_mcycles_o` are 0.
- R2: When `reg_wr_en_i` is high, `reg_wr_sel_i`=0 writes `reg_wr_data_i` to the enable register and `reg_wr_sel_i`=1 writes it to the flag register. The new value shows on `ie_o`/`if_o` the cycle after the write edge.
- R3: A high bit of `src_req_i` sets the matching flag bit at the clock edge. When the flag register is written in the same cycle, the result is the written value OR'd with the requests.
- R4: `ei_req_i` in OFF moves the master enable to SCHEDULED (1). A step then moves SCHEDULED to DELAYED (2), and a further step moves DELAYED to ON (3). Neither of those steps dispatches, even with sources pending. `ei_req_i` has no effect outside OFF.
- R5: `di_req_i` forces the master enable to OFF at the next edge from any state. It overrides a step or an enable request in the same cycle, and no dispatch happens in that cycle.
- R6: The serviceable set is `ie & if & SRC_MASK` (all five bits by default). A step taken while ON with a non-empty serviceable set raises `disp_valid_o` for exactly one cycle, starting the cycle after the step edge.
- R7: The lowest-numbered serviceable source wins: bit 0 first, then 1, 2, 3 and 4. The vector is 0x40 + 8 × index, giving 0x40, 0x48, 0x50, 0x58 and 0x60.
- R8: A dispatch sets the master enable to OFF and clears only the winning flag bit. A request for that same source in the step cycle keeps the bit set. `disp_mcycles_o` reads 5 while `disp_valid_o` is high, and it reads 0 otherwise, as does `disp_vector_o`.
- R9: A step while ON with an empty serviceable set changes nothing: the state stays ON, the flags are unchanged and no dispatch is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Instruction-boundary strobe |
| ei_req_i | input | 1 | Request to turn interrupts on (delayed) |
| di_req_i | input | 1 | Request to turn interrupts off (immediate) |
| src_req_i | input | 5 | Per-source peripheral requests |
| reg_wr_en_i | input | 1 | Register write strobe |
| reg_wr_sel_i | input | 1 | 0 = enable register, 1 = flag register |
| reg_wr_data_i | input | 5 | Register write data |
| ie_o | output | 5 | Enable register read value |
| if_o | output | 5 | Flag register read value |
| ime_o | output | 2 | Master-enable state (0 OFF, 1 SCHEDULED, 2 DELAYED, 3 ON) |
| disp_valid_o | output | 1 | One-cycle dispatch pulse |
| disp_vector_o | output | 16 | Vector address of the dispatched source |
| disp_mcycles_o | output | 3 | Machine-cycle cost of the dispatch |

## Verification
The bench places pending, enabled sources across both delay steps. A design that collapsed the two-step delay would dispatch early, and the bench would see an unexpected pulse. Mixed flag patterns probe the priority order and the vector spacing. A wrong encoder would return the wrong vector or clear the wrong bits, or clear more than one. The bench also fires a disable together with a step while ON, fires a request for the winning source in the dispatch cycle, and merges a flag write with a same-cycle request. A wrong ordering in any of these would show as a stray dispatch, a lost flag or an overwritten request. Enable requests outside OFF and steps with nothing serviceable must leave the state visibly untouched.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [1:0] {
        IME_OFF   = 2'd0,
        IME_SCHED = 2'd1,
        IME_DELAY = 2'd2,
        IME_ON    = 2'd3
    } ime_state_t;

endpackage

// File: rtl/irq_master_fsm.sv
module irq_master_fsm
    import irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step_i,
    input  logic       ei_req_i,
    input  logic       di_req_i,
    input  logic       pending_i,
    output ime_state_t state_o,
    output logic       take_o
);

    ime_state_t state_q;
    ime_state_t state_nxt;

    // next-state logic: kill first, then the per-state transitions
    always_comb begin
        state_nxt = state_q;
        if (di_req_i) begin
            state_nxt = IME_OFF;
        end else begin
            unique case (state_q)
                IME_OFF:   if (ei_req_i)             state_nxt = IME_SCHED;
                IME_SCHED: if (step_i)               state_nxt = IME_DELAY;
                IME_DELAY: if (step_i)               state_nxt = IME_ON;
                IME_ON:    if (step_i && pending_i)  state_nxt = IME_OFF;
                default:                             state_nxt = IME_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IME_OFF;
        else        state_q <= state_nxt;
    end

    // outputs
    always_comb begin
        state_o = state_q;
        take_o  = 1'b0;
        unique case (state_q)
            IME_ON:  take_o = step_i && pending_i && !di_req_i;
            default: take_o = 1'b0;
        endcase
    end

    // R4: first delay step
    assert_sched_to_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !di_req_i && state_q == IME_SCHED) |=> (state_q == IME_DELAY));

    // R4: second delay step
    assert_delay_to_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !di_req_i && state_q == IME_DELAY) |=> (state_q == IME_ON));

    // R5: disable wins from any state
    assert_kill_to_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        di_req_i |=> (state_q == IME_OFF));

endmodule

// File: rtl/irq_flag_regs.sv
module irq_flag_regs #(
    parameter int N_SRC = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic             wr_sel_i,
    input  logic [N_SRC-1:0] wr_data_i,
    input  logic [N_SRC-1:0] src_req_i,
    input  logic [N_SRC-1:0] clr_mask_i,
    output logic [N_SRC-1:0] ie_o,
    output logic [N_SRC-1:0] if_o
);

    logic [N_SRC-1:0] ie_q, if_q;
    logic [N_SRC-1:0] ie_nxt, if_nxt, if_base;

    always_comb begin
        ie_nxt  = (wr_en_i && !wr_sel_i) ? wr_data_i : ie_q;
        if_base = (wr_en_i &&  wr_sel_i) ? wr_data_i : (if_q & ~clr_mask_i);
        if_nxt  = if_base | src_req_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q <= '0;
            if_q <= '0;
        end else begin
            ie_q <= ie_nxt;
            if_q <= if_nxt;
        end
    end

    assign ie_o = ie_q;
    assign if_o = if_q;

    // R3: every request lands in the flag register
    assert_req_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (src_req_i != '0) |=> ((if_q & $past(src_req_i)) == $past(src_req_i)));

endmodule

// File: rtl/irq_priority_sel.sv
module irq_priority_sel #(
    parameter int N_SRC      = 5,
    parameter int VEC_W      = 16,
    parameter int VEC_BASE   = 'h40,
    parameter int VEC_STRIDE = 8
) (
    input  logic [N_SRC-1:0] req_i,
    output logic [N_SRC-1:0] grant_o,
    output logic [VEC_W-1:0] vector_o
);

    logic [N_SRC:0] blocked;
    assign blocked[0] = 1'b0;

    // fixed priority chain: lower index wins
    for (genvar i = 0; i < N_SRC; i++) begin : g_chain
        assign grant_o[i]   = req_i[i] && !blocked[i];
        assign blocked[i+1] = blocked[i] | req_i[i];
    end

    always_comb begin
        vector_o = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (grant_o[i]) vector_o = vector_o | VEC_W'(VEC_BASE + i * VEC_STRIDE);
        end
    end

endmodule

// File: rtl/irq_dispatch_ctrl.sv
module irq_dispatch_ctrl
    import irq_pkg::*;
#(
    parameter int          N_SRC      = 5,
    parameter logic [4:0]  SRC_MASK   = 5'h1F,
    parameter int          VEC_W      = 16,
    parameter int          VEC_BASE   = 'h40,
    parameter int          VEC_STRIDE = 8,
    parameter int          DISP_MCYC  = 5,
    localparam int         MCYC_W     = $clog2(DISP_MCYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              ei_req_i,
    input  logic              di_req_i,
    input  logic [N_SRC-1:0]  src_req_i,
    input  logic              reg_wr_en_i,
    input  logic              reg_wr_sel_i,
    input  logic [N_SRC-1:0]  reg_wr_data_i,
    output logic [N_SRC-1:0]  ie_o,
    output logic [N_SRC-1:0]  if_o,
    output logic [1:0]        ime_o,
    output logic              disp_valid_o,
    output logic [VEC_W-1:0]  disp_vector_o,
    output logic [MCYC_W-1:0] disp_mcycles_o
);

    logic [N_SRC-1:0] ie_q, if_q;
    logic [N_SRC-1:0] serviceable;
    logic [N_SRC-1:0] grant;
    logic [N_SRC-1:0] clr_mask;
    logic [VEC_W-1:0] sel_vector;
    logic             take;
    ime_state_t       ime_state;

    logic              valid_q;
    logic [VEC_W-1:0]  vector_q;
    logic [MCYC_W-1:0] mcyc_q;

    assign serviceable = ie_q & if_q & N_SRC'(SRC_MASK);
    assign clr_mask    = take ? grant : '0;

    irq_flag_regs #(.N_SRC(N_SRC)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (reg_wr_en_i),
        .wr_sel_i   (reg_wr_sel_i),
        .wr_data_i  (reg_wr_data_i),
        .src_req_i  (src_req_i),
        .clr_mask_i (clr_mask),
        .ie_o       (ie_q),
        .if_o       (if_q)
    );

    irq_priority_sel #(
        .N_SRC      (N_SRC),
        .VEC_W      (VEC_W),
        .VEC_BASE   (VEC_BASE),
        .VEC_STRIDE (VEC_STRIDE)
    ) u_prio (
        .req_i    (serviceable),
        .grant_o  (grant),
        .vector_o (sel_vector)
    );

    irq_master_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (step_i),
        .ei_req_i  (ei_req_i),
        .di_req_i  (di_req_i),
        .pending_i (|serviceable),
        .state_o   (ime_state),
        .take_o    (take)
    );

    // registered dispatch outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            vector_q <= '0;
            mcyc_q   <= '0;
        end else begin
            valid_q  <= take;
            vector_q <= take ? sel_vector : '0;
            mcyc_q   <= take ? MCYC_W'(DISP_MCYC) : '0;
        end
    end

    assign ie_o           = ie_q;
    assign if_o           = if_q;
    assign ime_o          = ime_state;
    assign disp_valid_o   = valid_q;
    assign disp_vector_o  = vector_q;
    assign disp_mcycles_o = mcyc_q;

    // R7: grant is a single serviceable source with nothing lower pending
    assert_grant_lowest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |-> ($onehot0(grant) && ((grant & serviceable) == grant)
                           && (((grant - 1'b1) & serviceable) == '0)));

    // R8: a dispatch leaves the master enable off and reports its cost
    assert_disp_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid_o |-> (ime_o == 2'd0 && disp_mcycles_o == MCYC_W'(DISP_MCYC)));

    // R6: the pulse lasts one cycle
    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid_o |=> !disp_valid_o);

    // R8: the winning flag is gone unless re-requested
    assert_flag_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> ((if_q & $past(grant)) == ($past(src_req_i) & $past(grant))));

endmodule

// File: tb/irq_dispatch_ctrl_tb.sv
module irq_dispatch_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        step_i, ei_req_i, di_req_i;
    logic [4:0]  src_req_i;
    logic        reg_wr_en_i, reg_wr_sel_i;
    logic [4:0]  reg_wr_data_i;
    logic [4:0]  ie_o, if_o;
    logic [1:0]  ime_o;
    logic        disp_valid_o;
    logic [15:0] disp_vector_o;
    logic [2:0]  disp_mcycles_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_dispatch_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .ei_req_i(ei_req_i),
        .di_req_i(di_req_i), .src_req_i(src_req_i), .reg_wr_en_i(reg_wr_en_i),
        .reg_wr_sel_i(reg_wr_sel_i), .reg_wr_data_i(reg_wr_data_i),
        .ie_o(ie_o), .if_o(if_o), .ime_o(ime_o), .disp_valid_o(disp_valid_o),
        .disp_vector_o(disp_vector_o), .disp_mcycles_o(disp_mcycles_o)
    );

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; step_i = 0; ei_req_i = 0; di_req_i = 0; src_req_i = '0;
        reg_wr_en_i = 0; reg_wr_sel_i = 0; reg_wr_data_i = '0;
        cycle(); cycle();
        rst_n = 1'b1;
        cycle();
    endtask

    task automatic wr_reg(bit sel, logic [4:0] d);
        reg_wr_en_i = 1; reg_wr_sel_i = sel; reg_wr_data_i = d;
        cycle();
        reg_wr_en_i = 0;
    endtask

    task automatic do_step();
        step_i = 1;
        cycle();
        step_i = 0;
    endtask

    task automatic go_on();
        ei_req_i = 1;
        cycle();
        ei_req_i = 0;
        do_step();
        do_step();
    endtask

    task automatic t_reset();
        do_reset();
        check("R1", "ie", ie_o, 0);
        check("R1", "if", if_o, 0);
        check("R1", "ime", ime_o, 0);
        check("R1", "valid", disp_valid_o, 0);
        check("R1", "vector", disp_vector_o, 0);
        check("R1", "mcycles", disp_mcycles_o, 0);
    endtask

    task automatic t_regs();
        do_reset();
        wr_reg(0, 5'h15);
        check("R2", "ie write", ie_o, 'h15);
        check("R2", "if untouched", if_o, 0);
        wr_reg(1, 5'h0A);
        check("R2", "if write", if_o, 'h0A);
        check("R2", "ie kept", ie_o, 'h15);
    endtask

    task automatic t_req_merge();
        do_reset();
        src_req_i = 5'h04;
        wr_reg(1, 5'h01);
        src_req_i = '0;
        check("R3", "write+req merge", if_o, 'h05);
        src_req_i = 5'h08;
        cycle();
        src_req_i = '0;
        check("R3", "req sets bit", if_o, 'h0D);
        wr_reg(1, 5'h00);
        check("R3", "write clears", if_o, 0);
    endtask

    task automatic t_enable_seq();
        do_reset();
        wr_reg(0, 5'h1F);
        wr_reg(1, 5'h04);
        ei_req_i = 1; cycle(); ei_req_i = 0;
        check("R4", "arm", ime_o, 1);
        do_step();
        check("R4", "first step", ime_o, 2);
        check("R4", "no dispatch step1", disp_valid_o, 0);
        ei_req_i = 1; cycle(); ei_req_i = 0;
        check("R4", "ei ignored in delayed", ime_o, 2);
        do_step();
        check("R4", "second step", ime_o, 3);
        check("R4", "no dispatch step2", disp_valid_o, 0);
        check("R4", "flag kept", if_o, 'h04);
        // dispatch of timer source
        do_step();
        check("R6", "valid", disp_valid_o, 1);
        check("R7", "timer vector", disp_vector_o, 'h50);
        check("R8", "mcycles", disp_mcycles_o, 5);
        check("R8", "ime off", ime_o, 0);
        check("R8", "flag cleared", if_o, 0);
        cycle();
        check("R6", "pulse one cycle", disp_valid_o, 0);
        check("R8", "vector idle", disp_vector_o, 0);
        check("R8", "mcycles idle", disp_mcycles_o, 0);
    endtask

    task automatic t_priority();
        logic [4:0] pats [5] = '{5'h18, 5'h1F, 5'h12, 5'h10, 5'h0C};
        foreach (pats[k]) begin
            int idx;
            idx = -1;
            for (int b = 4; b >= 0; b--) if (pats[k][b]) idx = b;
            do_reset();
            wr_reg(0, 5'h1F);
            wr_reg(1, pats[k]);
            go_on();
            do_step();
            check("R7", "priority valid", disp_valid_o, 1);
            check("R7", "priority vector", disp_vector_o, 'h40 + 8 * idx);
            check("R8", "only winner cleared", if_o, pats[k] & ~(5'h01 << idx));
        end
    endtask

    task automatic t_masked();
        do_reset();
        wr_reg(0, 5'h01);
        wr_reg(1, 5'h02);
        go_on();
        do_step();
        check("R9", "no dispatch", disp_valid_o, 0);
        check("R9", "stays on", ime_o, 3);
        check("R9", "flags kept", if_o, 'h02);
        check("R6", "enable gates", ie_o, 'h01);
    endtask

    task automatic t_disable();
        do_reset();
        wr_reg(0, 5'h1F);
        wr_reg(1, 5'h01);
        go_on();
        di_req_i = 1; step_i = 1;
        cycle();
        di_req_i = 0; step_i = 0;
        check("R5", "kill from on", ime_o, 0);
        check("R5", "no dispatch", disp_valid_o, 0);
        check("R5", "flag kept", if_o, 'h01);
        ei_req_i = 1; cycle(); ei_req_i = 0;
        di_req_i = 1; ei_req_i = 1;
        cycle();
        di_req_i = 0; ei_req_i = 0;
        check("R5", "kill from scheduled beats ei", ime_o, 0);
    endtask

    task automatic t_rereq();
        do_reset();
        wr_reg(0, 5'h1F);
        wr_reg(1, 5'h02);
        go_on();
        src_req_i = 5'h02;
        do_step();
        src_req_i = '0;
        check("R8", "rereq valid", disp_valid_o, 1);
        check("R7", "lcd vector", disp_vector_o, 'h48);
        check("R8", "rereq flag stays", if_o, 'h02);
    endtask

    initial begin
        t_reset();
        t_regs();
        t_req_merge();
        t_enable_seq();
        t_priority();
        t_masked();
        t_disable();
        t_rereq();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule